// File: doc/BRIEF.md
# Column-Parallel SIMD Processing Element Array

The block is a row of identical processing elements, one per image column, that all act on a single broadcast instruction in the same clock cycle. The opcode is decoded once, and the resulting control word goes to every element. Each element keeps a 10-bit accumulator and a one-bit condition flag. It takes one operand either from its accumulator or from its own column of the line-memory read bus. It takes the other operand from a nearby column that the instruction selects.

The controller presents an instruction together with a valid strobe. One clock edge later, every element presents its result on its write-back lane, with a per-lane enable. The result also lands in that element's accumulator. The flags of all elements are ORed onto one global line. The controller watches that line to end a data-dependent loop, for example to stop when no column still satisfies a comparison.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, every write-back enable is 0, every write-back lane is 0, the global flag is 0, and every accumulator and flag holds 0.
- R2: An instruction is taken only on a clock edge where `instr_valid` is 1, and it acts on all elements at that edge. Its results appear after that edge. On an edge with `instr_valid` at 0, every enable goes to 0 and all accumulators and flags keep their values.
- R3: Operand B of element i is line data from column i+d. Here d is `instr_offs` read as 3-bit two's complement and must lie between -2 and +3. The codes 3'b100 and 3'b101 (-4 and -3) give zero, and so does any column outside the array.
- R4: Operand A is the element's accumulator when `instr_asel` is 0, and its own column's line data when `instr_asel` is 1.
- R5: Opcode 1 (add) writes A+B, saturated at 1023. Opcode 2 (subtract) writes A-B, clamped at 0.
- R6: Opcode 3 (compare) sets the flag to 1 when A > B and to 0 otherwise. It writes nothing, and the accumulator is unchanged.
- R7: Opcode 4 (scale) writes B shifted right by `instr_shift` (0 to 3) bits.
- R8: Opcode 5 (multiply-accumulate) writes accumulator + A*B, saturated at 1023.
- R9: Opcode 6 (conditional pass) writes B only in elements whose flag is 1. Elements whose flag is 0 keep enable 0 and an unchanged accumulator.
- R10: `flag_any` is the OR of all element flags. Flags change only on a valid compare.
- R11: Opcode 0 (pass) writes B. Every written result is also loaded into that element's accumulator. Opcode 7 is a no-operation: nothing is written and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_op | input | 3 | Opcode |
| instr_asel | input | 1 | Operand A source: 0 accumulator, 1 own line data |
| instr_offs | input | 3 | Signed column offset for operand B |
| instr_shift | input | 2 | Right-shift amount for scale |
| line_rd | input | NUM_PE*DW | Line-memory read data, column 0 in the low bits |
| wb_data | output | NUM_PE*DW | Write-back data per column |
| wb_en | output | NUM_PE | Write-back enable per column |
| flag_any | output | 1 | OR of all element flags |

## Verification
The bench aims at the array edges. If the offset mapping were wrong, column 0 would read from the wrong neighbour, or the last column would fetch a stale or wrapped value instead of zero. It drives sums and products past 1023 and differences below 0, where a design without saturation or clamping would wrap to small or large values. It checks that a conditional pass leaves columns with a clear flag untouched. It also checks that compare, no-op and idle cycles leave the accumulators alone. It reads the accumulators back through an add with a zero operand, so a compare that wrote its result into the accumulator would show up as a wrong read-back value.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;

  typedef enum logic [2:0] {
    ALU_PASS = 3'd0,
    ALU_ADD  = 3'd1,
    ALU_SUB  = 3'd2,
    ALU_SHR  = 3'd3,
    ALU_MAC  = 3'd4
  } alu_e;

  // Shared control word produced once and broadcast to every element.
  typedef struct packed {
    alu_e alu;
    logic wr_always;
    logic wr_cond;
    logic upd_flag;
  } ctrl_t;

  localparam logic [2:0] OPC_PASS  = 3'd0;
  localparam logic [2:0] OPC_ADD   = 3'd1;
  localparam logic [2:0] OPC_SUB   = 3'd2;
  localparam logic [2:0] OPC_CMP   = 3'd3;
  localparam logic [2:0] OPC_SCALE = 3'd4;
  localparam logic [2:0] OPC_MAC   = 3'd5;
  localparam logic [2:0] OPC_CPASS = 3'd6;
  localparam logic [2:0] OPC_NOP   = 3'd7;

endpackage

// File: rtl/simd_decode.sv
module simd_decode
  import simd_pe_pkg::*;
(
  input  logic [2:0] op_code,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{alu: ALU_PASS, wr_always: 1'b0, wr_cond: 1'b0, upd_flag: 1'b0};
    case (op_code)
      OPC_PASS:  begin ctrl.alu = ALU_PASS; ctrl.wr_always = 1'b1; end
      OPC_ADD:   begin ctrl.alu = ALU_ADD;  ctrl.wr_always = 1'b1; end
      OPC_SUB:   begin ctrl.alu = ALU_SUB;  ctrl.wr_always = 1'b1; end
      OPC_CMP:   begin ctrl.upd_flag = 1'b1; end
      OPC_SCALE: begin ctrl.alu = ALU_SHR;  ctrl.wr_always = 1'b1; end
      OPC_MAC:   begin ctrl.alu = ALU_MAC;  ctrl.wr_always = 1'b1; end
      OPC_CPASS: begin ctrl.alu = ALU_PASS; ctrl.wr_cond = 1'b1; end
      default:   ;
    endcase
  end

endmodule

// File: rtl/simd_nbr_select.sv
module simd_nbr_select #(
  parameter int NUM_PE = 8,
  parameter int DW     = 10
) (
  input  logic [NUM_PE*DW-1:0] line_flat,
  input  logic [2:0]           offs,
  output logic [NUM_PE*DW-1:0] opb_flat
);

  localparam int MIN_OFF = -2;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PE; gi++) begin : g_col
      always_comb begin
        int off;
        off = int'($signed(offs));
        opb_flat[gi*DW +: DW] = '0;
        for (int c = 0; c < NUM_PE; c++) begin
          if ((off >= MIN_OFF) && (c == gi + off))
            opb_flat[gi*DW +: DW] = line_flat[c*DW +: DW];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/simd_flag_or.sv
module simd_flag_or #(
  parameter int NUM_PE = 8
) (
  input  logic [NUM_PE-1:0] flags,
  output logic              any
);

  logic [NUM_PE:0] chain;
  assign chain[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PE; gi++) begin : g_or
      assign chain[gi+1] = chain[gi] | flags[gi];
    end
  endgenerate

  assign any = chain[NUM_PE];

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pe_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  ctrl_t         ctrl,
  input  logic          asel,
  input  logic [1:0]    shamt,
  input  logic [DW-1:0] own_line,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] wb_data,
  output logic          wb_en,
  output logic          flag
);

  localparam int WW = 2*DW + 1;
  localparam logic [WW-1:0] MAXV = {{(WW-DW){1'b0}}, {DW{1'b1}}};

  logic [DW-1:0] acc;
  logic [DW-1:0] opa;
  logic [DW-1:0] result;
  logic          do_write;
  logic          cmp_gt;

  function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [DW:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[DW] ? {DW{1'b1}} : s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] clamp_sub(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return (x > y) ? (x - y) : '0;
  endfunction

  function automatic logic [DW-1:0] sat_mac(input logic [DW-1:0] a0, input logic [DW-1:0] x,
                                            input logic [DW-1:0] y);
    logic [WW-1:0] w;
    w = WW'(a0) + WW'(x) * WW'(y);
    return (w > MAXV) ? {DW{1'b1}} : w[DW-1:0];
  endfunction

  assign opa      = asel ? own_line : acc;
  assign cmp_gt   = (opa > opb);
  assign do_write = valid & (ctrl.wr_always | (ctrl.wr_cond & flag));

  always_comb begin
    case (ctrl.alu)
      ALU_ADD: result = sat_add(opa, opb);
      ALU_SUB: result = clamp_sub(opa, opb);
      ALU_SHR: result = opb >> shamt;
      ALU_MAC: result = sat_mac(acc, opa, opb);
      default: result = opb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      wb_data <= '0;
      wb_en   <= 1'b0;
      flag    <= 1'b0;
    end else begin
      wb_en <= do_write;
      if (do_write) begin
        wb_data <= result;
        acc     <= result;
      end
      if (valid && ctrl.upd_flag)
        flag <= cmp_gt;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!wb_en && $stable(acc) && $stable(flag)));

  p_cmp_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.upd_flag) |=> (!wb_en && $stable(acc)));

  p_cpass_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ctrl.wr_cond && !flag) |=> (!wb_en && $stable(acc)));

  p_acc_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (acc == wb_data));

  p_flag_only_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && ctrl.upd_flag) |=> $stable(flag));

endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pe_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int DW     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [2:0]           instr_op,
  input  logic                 instr_asel,
  input  logic [2:0]           instr_offs,
  input  logic [1:0]           instr_shift,
  input  logic [NUM_PE*DW-1:0] line_rd,
  output logic [NUM_PE*DW-1:0] wb_data,
  output logic [NUM_PE-1:0]    wb_en,
  output logic                 flag_any
);

  ctrl_t                 ctrl;
  logic [NUM_PE*DW-1:0]  opb_flat;
  logic [NUM_PE-1:0]     pe_flag;

  simd_decode u_decode (
    .op_code (instr_op),
    .ctrl    (ctrl)
  );

  simd_nbr_select #(.NUM_PE(NUM_PE), .DW(DW)) u_nbr (
    .line_flat (line_rd),
    .offs      (instr_offs),
    .opb_flat  (opb_flat)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PE; gi++) begin : g_pe
      simd_pe #(.DW(DW)) u_pe (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (instr_valid),
        .ctrl     (ctrl),
        .asel     (instr_asel),
        .shamt    (instr_shift),
        .own_line (line_rd[gi*DW +: DW]),
        .opb      (opb_flat[gi*DW +: DW]),
        .wb_data  (wb_data[gi*DW +: DW]),
        .wb_en    (wb_en[gi]),
        .flag     (pe_flag[gi])
      );
    end
  endgenerate

  simd_flag_or #(.NUM_PE(NUM_PE)) u_flag_or (
    .flags (pe_flag),
    .any   (flag_any)
  );

  p_edge_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_offs == 3'b111) |-> (opb_flat[DW-1:0] == '0));

  p_far_code_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_offs[2:1] == 2'b10) |-> (opb_flat == '0));

  p_flag_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_any) |-> $past(instr_valid));

  p_write_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en != '0) |-> $past(instr_valid));

endmodule

// File: tb/simd_pe_array_bench.sv
module simd_pe_array_bench;

  localparam int NPE = 8;
  localparam int DW  = 10;
  localparam int MAXV = (1 << DW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 instr_valid = 1'b0;
  logic [2:0]           instr_op = '0;
  logic                 instr_asel = 1'b0;
  logic [2:0]           instr_offs = '0;
  logic [1:0]           instr_shift = '0;
  logic [NPE*DW-1:0]    line_rd = '0;
  logic [NPE*DW-1:0]    wb_data;
  logic [NPE-1:0]       wb_en;
  logic                 flag_any;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  int lines_m [NPE];
  int acc_m   [NPE];
  bit flag_m  [NPE];

  always #2 clk = ~clk;

  simd_pe_array #(.NUM_PE(NPE), .DW(DW)) u_simd_pe_array (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_asel(instr_asel), .instr_offs(instr_offs), .instr_shift(instr_shift),
    .line_rd(line_rd), .wb_data(wb_data), .wb_en(wb_en), .flag_any(flag_any)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int nbr_val(input int col, input logic [2:0] code);
    int d;
    int c;
    d = (code > 3) ? int'(code) - 8 : int'(code);
    if (d < -2) return 0;
    c = col + d;
    if (c < 0 || c >= NPE) return 0;
    return lines_m[c];
  endfunction

  function automatic int cap(input int x);
    if (x > MAXV) return MAXV;
    if (x < 0) return 0;
    return x;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd1, 3'd2: return "R5";
      3'd3:       return "R6";
      3'd4:       return "R7";
      3'd5:       return "R8";
      3'd6:       return "R9";
      default:    return "R11";
    endcase
  endfunction

  // Called at a negative edge; applies one cycle of stimulus and checks after the next rising edge.
  task automatic step(input bit v, input logic [2:0] op, input bit asel, input logic [2:0] offs,
                      input logic [1:0] sh, input string tag_in);
    string tag;
    int exp_en  [NPE];
    int exp_dat [NPE];
    bit nflag   [NPE];
    bit any;
    tag = (tag_in == "") ? (v ? op_tag(op) : "R2") : tag_in;
    for (int i = 0; i < NPE; i++) line_rd[i*DW +: DW] = DW'(lines_m[i]);
    instr_valid = v; instr_op = op; instr_asel = asel; instr_offs = offs; instr_shift = sh;
    for (int i = 0; i < NPE; i++) begin
      int a;
      int b;
      int r;
      bit w;
      a = asel ? lines_m[i] : acc_m[i];
      b = nbr_val(i, offs);
      r = b;
      w = 1'b0;
      nflag[i] = flag_m[i];
      if (v) begin
        case (op)
          3'd0: begin r = b; w = 1'b1; end
          3'd1: begin r = cap(a + b); w = 1'b1; end
          3'd2: begin r = cap(a - b); w = 1'b1; end
          3'd3: nflag[i] = (a > b);
          3'd4: begin r = b / (1 << sh); w = 1'b1; end
          3'd5: begin r = cap(acc_m[i] + a * b); w = 1'b1; end
          3'd6: begin r = b; w = flag_m[i]; end
          default: ;
        endcase
      end
      exp_en[i] = w;
      exp_dat[i] = r;
    end
    @(negedge clk);
    any = 1'b0;
    for (int i = 0; i < NPE; i++) begin
      check(wb_en[i] == exp_en[i][0], tag, $sformatf("wb_en[%0d]", i), int'(wb_en[i]), exp_en[i]);
      if (exp_en[i] != 0) begin
        check(int'(wb_data[i*DW +: DW]) == exp_dat[i], tag, $sformatf("wb_data[%0d]", i),
              int'(wb_data[i*DW +: DW]), exp_dat[i]);
        acc_m[i] = exp_dat[i];
      end
      flag_m[i] = nflag[i];
      any |= nflag[i];
    end
    check(flag_any == any, (op == 3'd3 && v) ? "R10" : tag, "flag_any", int'(flag_any), int'(any));
  endtask

  // Reads every accumulator back: add with operand A = accumulator and a zero operand B.
  task automatic readback(input string tag);
    step(1'b1, 3'd1, 1'b0, 3'b100, 2'd0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < NPE; i++) begin acc_m[i] = 0; flag_m[i] = 0; lines_m[i] = 0; end
    repeat (3) @(negedge clk);
    check(wb_en == '0, "R1", "wb_en in reset", int'(wb_en), 0);
    check(wb_data == '0, "R1", "wb_data in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(flag_any == 1'b0, "R1", "flag_any after reset", int'(flag_any), 0);
    for (int i = 0; i < NPE; i++) lines_m[i] = 50 + i;
    readback("R1");

    // Neighbour offsets and array edges
    for (int i = 0; i < NPE; i++) lines_m[i] = 10 * (i + 1);
    step(1'b1, 3'd0, 1'b0, 3'b000, 2'd0, "R11");
    step(1'b1, 3'd0, 1'b0, 3'b011, 2'd0, "R3");
    step(1'b1, 3'd0, 1'b0, 3'b110, 2'd0, "R3");
    step(1'b1, 3'd0, 1'b0, 3'b111, 2'd0, "R3");
    step(1'b1, 3'd0, 1'b0, 3'b001, 2'd0, "R3");
    step(1'b1, 3'd0, 1'b0, 3'b101, 2'd0, "R3");
    step(1'b1, 3'd0, 1'b0, 3'b100, 2'd0, "R3");

    // Operand A source
    for (int i = 0; i < NPE; i++) lines_m[i] = 100 + 7 * i;
    step(1'b1, 3'd0, 1'b0, 3'b000, 2'd0, "R11");
    for (int i = 0; i < NPE; i++) lines_m[i] = 3 * i;
    step(1'b1, 3'd1, 1'b0, 3'b000, 2'd0, "R4");
    step(1'b1, 3'd1, 1'b1, 3'b001, 2'd0, "R4");

    // Saturation and clamping
    for (int i = 0; i < NPE; i++) lines_m[i] = 1000 - i;
    step(1'b1, 3'd1, 1'b1, 3'b000, 2'd0, "R5");
    for (int i = 0; i < NPE; i++) lines_m[i] = (i % 2) ? 900 : 5;
    step(1'b1, 3'd2, 1'b1, 3'b001, 2'd0, "R5");
    step(1'b1, 3'd2, 1'b1, 3'b111, 2'd0, "R5");

    // Scaling
    for (int i = 0; i < NPE; i++) lines_m[i] = 1023 - 37 * i;
    for (int s = 0; s < 4; s++) step(1'b1, 3'd4, 1'b0, 3'b000, 2'(s), "R7");

    // Multiply-accumulate, small then saturating
    for (int i = 0; i < NPE; i++) lines_m[i] = i + 1;
    step(1'b1, 3'd0, 1'b0, 3'b000, 2'd0, "R11");
    step(1'b1, 3'd5, 1'b1, 3'b000, 2'd0, "R8");
    for (int i = 0; i < NPE; i++) lines_m[i] = 200 + i;
    step(1'b1, 3'd5, 1'b1, 3'b000, 2'd0, "R8");

    // Compare, then conditional pass, then the accumulator must be untouched where the flag is clear
    for (int i = 0; i < NPE; i++) lines_m[i] = (i < 4) ? 20 : 600;
    step(1'b1, 3'd0, 1'b1, 3'b101, 2'd0, "R11");
    step(1'b1, 3'd3, 1'b1, 3'b100, 2'd0, "R6");
    readback("R6");
    for (int i = 0; i < NPE; i++) lines_m[i] = 333 + i;
    step(1'b1, 3'd6, 1'b0, 3'b000, 2'd0, "R9");
    readback("R9");
    for (int i = 0; i < NPE; i++) lines_m[i] = 1000;
    step(1'b1, 3'd3, 1'b0, 3'b000, 2'd0, "R10");
    step(1'b1, 3'd6, 1'b0, 3'b000, 2'd0, "R9");

    // Idle cycles and no-op leave state alone
    for (int i = 0; i < NPE; i++) lines_m[i] = 999;
    step(1'b0, 3'd0, 1'b1, 3'b000, 2'd0, "R2");
    step(1'b0, 3'd3, 1'b1, 3'b000, 2'd0, "R2");
    readback("R2");
    step(1'b1, 3'd7, 1'b1, 3'b000, 2'd0, "R11");
    readback("R11");

    // Constrained random mix
    for (int k = 0; k < 600; k++) begin
      bit v;
      for (int i = 0; i < NPE; i++)
        lines_m[i] = ($urandom % 4 == 0) ? (MAXV - int'($urandom % 8)) : int'($urandom % (MAXV + 1));
      v = ($urandom % 5) != 0;
      step(v, 3'($urandom), 1'($urandom), 3'($urandom), 2'($urandom), "");
      if (k % 50 == 0) readback("R11");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule